// File: doc/BRIEF.md
# Instruction Result Router with Method Send Channel

This unit sits at the back end of a small command-processing core. Once an instruction has computed its result, the unit applies the instruction's 3-bit result code. The code decides whether the destination register receives the computed value or a value popped from the incoming parameter stream. It also decides whether the value is loaded into the method-address register, and whether an output write of (address, data) goes out on a valid/ready send channel.

The method-address register holds a 12-bit target address and a 6-bit increment, loaded together from result bits 17:0. Every send carries the current address. After the send, the address advances by the increment, modulo 4096. The increment itself is kept. A code that both loads and sends uses the newly loaded address for that send.

An operation is presented with `op_valid_i` and is held until `done_o`. While the send channel is not ready, or a needed parameter has not yet arrived, the unit raises `busy_o` and commits nothing. Fetching from a stream that has ended writes zero and sets a sticky underflow flag.

Top module: `mr_router`

## Requirements
- R1: After reset no register write, pop or send is active, `busy_o` and `underflow_o` are 0, and the method address and increment are 0, so the first send goes to address 0.
- R2: Code 0 writes the popped parameter to the destination and pops exactly one entry. Code 1 writes the result and neither pops nor sends. A pop happens only when a parameter is present.
- R3: Code 2 writes the result and loads result[17:0] into the method register (address = bits 11:0, increment = bits 17:12) without sending. Code 5 writes a popped parameter and loads the result the same way.
- R4: Code 3 writes a popped parameter and sends the result. Code 4 writes the result and sends it.
- R5: Code 6 writes the result, loads it into the method register, then sends a popped parameter to the newly loaded address.
- R6: Code 7 writes the result, loads it into the method register, then sends result bits 17:12, zero-extended, to the newly loaded address.
- R7: After each accepted send the address becomes (address + increment) mod 4096 and the increment is retained. A zero increment leaves the address unchanged.
- R8: A destination of register 0 suppresses the register write, while the pop and send side effects still take place.
- R9: While a send awaits `snd_ready_i`, or a needed parameter is absent and the stream has not ended, `busy_o` is 1 and no write, pop or method-register change occurs. The operation completes in the first cycle in which the condition clears.
- R10: A fetch with no parameter present and `param_end_i` set completes, writes 0, and sets `underflow_o`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation presented, held until done_o |
| res_code_i | input | 3 | Result code 0..7 |
| dst_i | input | 3 | Destination register index |
| result_i | input | 32 | Computed instruction result |
| done_o | output | 1 | Operation committed this cycle |
| busy_o | output | 1 | Operation presented but stalled |
| param_valid_i | input | 1 | Parameter stream head is valid |
| param_end_i | input | 1 | Parameter stream has ended |
| param_data_i | input | 32 | Parameter stream head value |
| param_pop_o | output | 1 | Consume stream head |
| underflow_o | output | 1 | Sticky fetch-underflow flag |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 3 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| snd_valid_o | output | 1 | Send channel valid |
| snd_ready_i | input | 1 | Send channel ready |
| snd_addr_o | output | 12 | Send target address |
| snd_data_o | output | 32 | Send data |

## Verification
The bench builds the block with its defaults: 32-bit data, a 12-bit address, a 6-bit increment and eight registers. With these values an address of 0xFFF with increment 1 reaches the modulo-4096 wrap in one send. The full 6-bit increment field can be exercised in code 7, where it is both loaded and sent as data. A bench-side model of address and increment predicts the target of every send across loads, zero increments and stalls.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic [2:0] {
    RES_FETCH          = 3'd0,
    RES_MOVE           = 3'd1,
    RES_MOVE_SETM      = 3'd2,
    RES_FETCH_SEND     = 3'd3,
    RES_MOVE_SEND      = 3'd4,
    RES_FETCH_SETM     = 3'd5,
    RES_MOVE_SETM_SNDP = 3'd6,
    RES_MOVE_SETM_SNDI = 3'd7
  } res_op_e;

  typedef struct packed {
    logic wr_fetch;   // destination takes popped parameter
    logic load_m;     // load method register from result
    logic send;       // issue a send
    logic snd_param;  // send data is a popped parameter
    logic snd_inc;    // send data is result increment field
  } route_t;
endpackage

// File: rtl/mr_decode.sv
module mr_decode
  import mr_pkg::*;
(
  input  logic [2:0] code_i,
  output route_t     route_o
);
  always_comb begin
    route_o = '0;
    unique case (res_op_e'(code_i))
      RES_FETCH:          route_o.wr_fetch = 1'b1;
      RES_MOVE:           ;
      RES_MOVE_SETM:      route_o.load_m = 1'b1;
      RES_FETCH_SEND: begin
        route_o.wr_fetch = 1'b1;
        route_o.send     = 1'b1;
      end
      RES_MOVE_SEND:      route_o.send = 1'b1;
      RES_FETCH_SETM: begin
        route_o.wr_fetch = 1'b1;
        route_o.load_m   = 1'b1;
      end
      RES_MOVE_SETM_SNDP: begin
        route_o.load_m    = 1'b1;
        route_o.send      = 1'b1;
        route_o.snd_param = 1'b1;
      end
      RES_MOVE_SETM_SNDI: begin
        route_o.load_m  = 1'b1;
        route_o.send    = 1'b1;
        route_o.snd_inc = 1'b1;
      end
      default: route_o = '0;
    endcase
  end
endmodule

// File: rtl/mr_param_fetch.sv
module mr_param_fetch #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              need_i,
  input  logic              commit_i,
  input  logic              param_valid_i,
  input  logic              param_end_i,
  input  logic [DATA_W-1:0] param_data_i,
  output logic              ok_o,
  output logic [DATA_W-1:0] value_o,
  output logic              pop_o,
  output logic              underflow_o
);
  logic uf_q;

  assign ok_o    = !need_i || param_valid_i || param_end_i;
  assign value_o = param_valid_i ? param_data_i : '0;
  assign pop_o   = commit_i && need_i && param_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uf_q <= 1'b0;
    else if (commit_i && need_i && !param_valid_i) uf_q <= 1'b1;
  end
  assign underflow_o = uf_q;

  AST_POP_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> param_valid_i); // R2
  AST_UF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o); // R10
endmodule

// File: rtl/mr_method_reg.sv
module mr_method_reg #(
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6,
  localparam int M_W   = ADDR_W + INC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              load_i,
  input  logic              send_i,
  input  logic [M_W-1:0]    load_val_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [M_W-1:0]    madr_q, base, madr_d;
  logic [INC_W-1:0]  base_inc;
  logic [ADDR_W-1:0] base_adr;

  assign base     = load_i ? load_val_i : madr_q;
  assign base_inc = base[M_W-1:ADDR_W];
  assign base_adr = base[ADDR_W-1:0];
  assign addr_o   = base_adr;

  always_comb begin
    madr_d = madr_q;
    if (commit_i) begin
      if (send_i) madr_d = {base_inc, base_adr + ADDR_W'(base_inc)};
      else        madr_d = base;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) madr_q <= '0;
    else         madr_q <= madr_d;
  end

  AST_INC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && send_i) |=> madr_q[M_W-1:ADDR_W] == $past(base_inc)); // R7
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(madr_q)); // R9
endmodule

// File: rtl/mr_router.sv
module mr_router
  import mr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6,
  parameter int REG_N  = 8,
  localparam int REG_W = $clog2(REG_N),
  localparam int M_W   = ADDR_W + INC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        res_code_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              done_o,
  output logic              busy_o,
  input  logic              param_valid_i,
  input  logic              param_end_i,
  input  logic [DATA_W-1:0] param_data_i,
  output logic              param_pop_o,
  output logic              underflow_o,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              snd_valid_o,
  input  logic              snd_ready_i,
  output logic [ADDR_W-1:0] snd_addr_o,
  output logic [DATA_W-1:0] snd_data_o
);
  route_t            route;
  logic              need_fetch, fetch_ok, send_ok, commit;
  logic [DATA_W-1:0] fetch_val;

  mr_decode u_dec (.code_i(res_code_i), .route_o(route));

  assign need_fetch = route.wr_fetch || route.snd_param;

  mr_param_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk_i, .rst_ni,
    .need_i(need_fetch), .commit_i(commit),
    .param_valid_i, .param_end_i, .param_data_i,
    .ok_o(fetch_ok), .value_o(fetch_val),
    .pop_o(param_pop_o), .underflow_o
  );

  mr_method_reg #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_madr (
    .clk_i, .rst_ni,
    .commit_i(commit), .load_i(route.load_m), .send_i(route.send),
    .load_val_i(result_i[M_W-1:0]), .addr_o(snd_addr_o)
  );

  assign send_ok = !route.send || snd_ready_i;
  assign commit  = op_valid_i && fetch_ok && send_ok;
  assign done_o  = commit;
  assign busy_o  = op_valid_i && !commit;

  assign snd_valid_o = op_valid_i && route.send && fetch_ok;
  always_comb begin
    if (route.snd_param)    snd_data_o = fetch_val;
    else if (route.snd_inc) snd_data_o = DATA_W'(result_i[M_W-1:ADDR_W]);
    else                    snd_data_o = result_i;
  end

  assign rf_we_o    = commit && (dst_i != '0);
  assign rf_waddr_o = dst_i;
  assign rf_wdata_o = route.wr_fetch ? fetch_val : result_i;

  AST_NO_WR_R0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_waddr_o != '0); // R8
  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!rf_we_o && !param_pop_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> (!snd_valid_o && !rf_we_o && !param_pop_o)); // R1
  AST_SEND_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snd_valid_o && snd_ready_i) |-> done_o); // R4
endmodule

// File: tb/mr_router_tb_top.sv
module mr_router_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        op_valid = 0, pend = 0, ready = 1;
  logic [2:0]  code = 0, dst = 0;
  logic [31:0] res = 0;
  logic        done, busy, pvalid, pop, uf, we, svalid;
  logic [2:0]  waddr;
  logic [31:0] wdata, sdata, pdata;
  logic [11:0] saddr;

  logic [31:0] params [0:15];
  int pcount = 0, pidx = 0;
  assign pvalid = pidx < pcount;
  assign pdata  = params[pidx[3:0]];
  always @(posedge clk) if (pop) pidx <= pidx + 1;

  mr_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .res_code_i(code),
    .dst_i(dst), .result_i(res), .done_o(done), .busy_o(busy),
    .param_valid_i(pvalid), .param_end_i(pend), .param_data_i(pdata),
    .param_pop_o(pop), .underflow_o(uf), .rf_we_o(we), .rf_waddr_o(waddr),
    .rf_wdata_o(wdata), .snd_valid_o(svalid), .snd_ready_i(ready),
    .snd_addr_o(saddr), .snd_data_o(sdata)
  );

  int errors = 0, checks = 0;
  int m_addr = 0, m_inc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v);
    params[pcount[3:0]] = v;
    pcount++;
  endtask

  // Present one op that should complete in the same cycle; check outputs.
  task automatic op(input string tag, input logic [2:0] c, input logic [2:0] d,
                    input logic [31:0] r, input logic ewe, input logic [31:0] ewd,
                    input logic epop, input logic esnd, input logic [31:0] esd);
    @(negedge clk);
    op_valid = 1; code = c; dst = d; res = r;
    if (c == 2 || c == 5 || c == 6 || c == 7) begin
      m_addr = int'(r[11:0]); m_inc = int'(r[17:12]);
    end
    #1;
    chk({tag, " done"}, {31'd0, done}, 1);
    chk({tag, " we"}, {31'd0, we}, {31'd0, ewe});
    if (ewe) begin
      chk({tag, " waddr"}, {29'd0, waddr}, {29'd0, d});
      chk({tag, " wdata"}, wdata, ewd);
    end
    chk({tag, " pop"}, {31'd0, pop}, {31'd0, epop});
    chk({tag, " svalid"}, {31'd0, svalid}, {31'd0, esnd});
    if (esnd) begin
      chk({tag, " saddr"}, {20'd0, saddr}, 32'(m_addr));
      chk({tag, " sdata"}, sdata, esd);
      m_addr = (m_addr + m_inc) % 4096;
    end
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 we", {31'd0, we}, 0);
    chk("R1 svalid", {31'd0, svalid}, 0);
    chk("R1 pop", {31'd0, pop}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 underflow", {31'd0, uf}, 0);
    op("R1 first send addr0", 3'd4, 3'd1, 32'hABC, 1, 32'hABC, 0, 1, 32'hABC);
  endtask

  task automatic t_code01;
    push(32'h11);
    op("R2 code0", 3'd0, 3'd2, 32'h5555, 1, 32'h11, 1, 0, 0);
    op("R2 code1", 3'd1, 3'd3, 32'h77, 1, 32'h77, 0, 0, 0);
  endtask

  task automatic t_load;
    op("R3 code2", 3'd2, 3'd4, 32'h3100, 1, 32'h3100, 0, 0, 0);
    op("R7 send1", 3'd4, 3'd1, 32'hD1, 1, 32'hD1, 0, 1, 32'hD1);   // addr 0x100
    op("R7 send2", 3'd4, 3'd1, 32'hD2, 1, 32'hD2, 0, 1, 32'hD2);   // addr 0x103
    push(32'h33);
    op("R3 code5", 3'd5, 3'd5, 32'h0200, 1, 32'h33, 1, 0, 0);
    op("R7 zero inc a", 3'd4, 3'd1, 32'h1, 1, 32'h1, 0, 1, 32'h1);
    op("R7 zero inc b", 3'd4, 3'd1, 32'h2, 1, 32'h2, 0, 1, 32'h2);
  endtask

  task automatic t_code3_wrap;
    op("R8 code2 dst0", 3'd2, 3'd0, 32'h1FFF, 0, 0, 0, 0, 0);
    push(32'h44);
    op("R4 code3", 3'd3, 3'd6, 32'h99, 1, 32'h44, 1, 1, 32'h99); // addr 0xFFF
    op("R7 wrap", 3'd4, 3'd1, 32'h2, 1, 32'h2, 0, 1, 32'h2);     // addr 0x000
  endtask

  task automatic t_code6;
    push(32'h55);
    op("R5 code6", 3'd6, 3'd7, 32'h2010, 1, 32'h2010, 1, 1, 32'h55);
    op("R5 after", 3'd4, 3'd1, 32'h3, 1, 32'h3, 0, 1, 32'h3);    // addr 0x012
  endtask

  task automatic t_code7;
    op("R6 code7", 3'd7, 3'd1, 32'h2A020, 1, 32'h2A020, 0, 1, 32'h2A);
    op("R6 after", 3'd4, 3'd2, 32'h4, 1, 32'h4, 0, 1, 32'h4);    // addr 0x04A
  endtask

  task automatic t_zero_dst;
    push(32'h88);
    op("R8 code3 dst0", 3'd3, 3'd0, 32'h66, 0, 0, 1, 1, 32'h66);
  endtask

  task automatic t_stall_ready;
    int a0;
    a0 = m_addr;
    @(negedge clk);
    ready = 0; op_valid = 1; code = 3'd4; dst = 3'd1; res = 32'h123;
    for (int i = 0; i < 2; i++) begin
      #1;
      chk("R9 busy on ready", {31'd0, busy}, 1);
      chk("R9 no write", {31'd0, we}, 0);
      chk("R9 svalid held", {31'd0, svalid}, 1);
      chk("R9 addr held", {20'd0, saddr}, 32'(a0));
      @(negedge clk);
    end
    ready = 1; #1;
    chk("R9 completes", {31'd0, done}, 1);
    chk("R9 write", {31'd0, we}, 1);
    m_addr = (m_addr + m_inc) % 4096;
    @(negedge clk); op_valid = 0;
    op("R9 next addr", 3'd4, 3'd1, 32'h5, 1, 32'h5, 0, 1, 32'h5);
  endtask

  task automatic t_stall_param;
    @(negedge clk);
    op_valid = 1; code = 3'd0; dst = 3'd2; res = 32'h0;
    #1;
    chk("R9 busy on param", {31'd0, busy}, 1);
    chk("R9 no pop", {31'd0, pop}, 0);
    chk("R9 no write p", {31'd0, we}, 0);
    @(negedge clk);
    push(32'hBEEF); #1;
    chk("R9 param done", {31'd0, done}, 1);
    chk("R9 param data", wdata, 32'hBEEF);
    chk("R9 param pop", {31'd0, pop}, 1);
    @(negedge clk); op_valid = 0;
  endtask

  task automatic t_underflow;
    pend = 1;
    chk("R10 flag clear before", {31'd0, uf}, 0);
    op("R10 fetch empty", 3'd0, 3'd3, 32'h9, 1, 32'h0, 0, 0, 0);
    chk("R10 flag set", {31'd0, uf}, 1);
    op("R10 later op", 3'd1, 3'd3, 32'h9, 1, 32'h9, 0, 0, 0);
    chk("R10 flag sticky", {31'd0, uf}, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_code01();
        t_load();
        t_code3_wrap();
        t_code6();
        t_code7();
        t_zero_dst();
        t_stall_ready();
        t_stall_param();
        t_underflow();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule